// File: doc/BRIEF.md
# Hypervisor Bandwidth-Cap Register Access Gate

This block decides what happens when software touches a 64-bit hypervisor-level bandwidth-cap control register. For each access it looks at the requesting exception level and the feature and capability flags. It also looks at the three nested-virtualization control bits, two independent EL3 trap controls, and the secure-debug-disable flags. From these it selects exactly one outcome: undefined, trap to EL2, trap to EL3, redirect to memory, or direct register access. The decision is combinational, so the action outputs are valid in the same cycle as the access inputs.

The register lives inside the block. A write is captured at the next clock edge, and only when the decision for that write is a direct access. Before storage, reserved bits are forced to zero. Reads return the stored value in the cycle of a direct read. Exception entry and the memory transaction for a redirect are handled by neighbouring logic. That logic consumes the one-hot action, the 6-bit syndrome class and the redirect offset. The register's system encoding is op0=0b11, op1=0b100, CRn=0b1010, CRm=0b0101, op2=0b110, and decoding it happens upstream of `acc_valid`.

Top module: `hyp_bwcap_gate`

## Requirements
- R1: While `acc_valid` is 1, exactly one of the five action outputs is 1. While it is 0, all five are 0. The output vector is ordered {undef, trap_el2, trap_el3, redirect, direct}.
- R2: If `feat_present` or `hyp_cap` is 0, every valid access is undefined, at any exception level.
- R3: A valid access with `acc_el`=0 is undefined.
- R4: At `acc_el`=1 with `nest_ctl[2]`=1 and `nest_ctl[0]`=1, the action is redirect. `mem_ofs` then reads 16'h0910; otherwise it reads 0.
- R5: At `acc_el`=1 with `nest_ctl[0]`=1 and `nest_ctl[2]`=0, an EL3 trap is taken when (`ver_base` and `lower_trap_a`) is 1 or `lower_pass_b` is 0. Otherwise the access traps to EL2. Every trap reports `syn_class`=6'h18; every other action reports 0.
- R6: At `acc_el`=1 with `nest_ctl[0]`=0, the access is undefined, whatever `nest_ctl[2:1]` hold.
- R7: At `acc_el`=2, when `sdd_prio` is 1 and the EL3 trap condition of R5 holds, the access is undefined and no trap is reported.
- R8: When an EL3 trap would be taken at EL1 or EL2 but `sdd_undef` is 1, the access is undefined instead.
- R9: At `acc_el`=2 with no EL3 trap condition, and at `acc_el`=3 always, the action is direct access. The `sdd` flags have no effect in that case.
- R10: The stored register changes only on a write whose action is direct. Writes that are undefined, trapped or redirected leave it unchanged.
- R11: On a stored write, bits 61:32 become 0 and bits 63 and 62 are kept. Bits 31:16 are kept only when the written bit 63 is 1. Of bits 15:0, only the top FRAC_W (default 12) are kept, so bits 3:0 become 0.
- R12: `rd_data` shows the stored value during a valid direct read and 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset, clears the register |
| acc_valid | input | 1 | An access to the register is presented this cycle |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| acc_el | input | 2 | Exception level of the requester |
| acc_wdata | input | 64 | Write data |
| feat_present | input | 1 | Bandwidth-control feature implemented |
| hyp_cap | input | 1 | Hypervisor-control capability bit |
| ver_base | input | 1 | Base feature version present, qualifies `lower_trap_a` |
| nest_ctl | input | 3 | Nested-virtualization control bits {bit2, bit1, bit0} |
| lower_trap_a | input | 1 | EL3 control: 1 traps lower-level accesses |
| lower_pass_b | input | 1 | EL3 control, active low: 0 traps lower-level accesses |
| sdd_undef | input | 1 | Secure-debug-disable: turns an EL3 trap into undefined |
| sdd_prio | input | 1 | Secure-debug-disable priority: EL2 undefined check first |
| act_undef | output | 1 | Access is undefined |
| act_trap_el2 | output | 1 | Access traps to EL2 |
| act_trap_el3 | output | 1 | Access traps to EL3 |
| act_redirect | output | 1 | Access goes to memory at `mem_ofs` |
| act_direct | output | 1 | Access reaches the register |
| syn_class | output | 6 | Syndrome class on a trap, else 0 |
| mem_ofs | output | 16 | Redirect offset on redirect, else 0 |
| rd_data | output | 64 | Read data on a direct read, else 0 |

## Verification
The bench targets the ordering corners. The first is EL1 with both nested bits set while EL3 traps are armed: a design that checks the traps first would trap instead of redirecting. The second is EL2 with the priority flag, where a design with the checks in the wrong order would report an EL3 trap rather than undefined. It also confirms that `lower_trap_a` alone is ignored when `ver_base` is 0, and that an active-low pass bit of 0 traps on its own. On the storage side, it writes through trapped and undefined paths and then reads at EL3 to catch a register that updates too eagerly. It also writes all-ones with bit 63 set and then clear, to catch a mask that keeps reserved or integer bits.

// File: rtl/bwcap_gate_pkg.sv
package bwcap_gate_pkg;

    typedef enum logic [2:0] {
        ACT_NONE   = 3'd0,
        ACT_UNDEF  = 3'd1,
        ACT_TRAP2  = 3'd2,
        ACT_TRAP3  = 3'd3,
        ACT_REDIR  = 3'd4,
        ACT_DIRECT = 3'd5
    } act_e;

    localparam logic [1:0] LVL_USER  = 2'd0;
    localparam logic [1:0] LVL_KERN  = 2'd1;
    localparam logic [1:0] LVL_HYP   = 2'd2;
    localparam logic [1:0] LVL_MON   = 2'd3;

    typedef struct packed {
        act_e        act;
        logic [5:0]  syn;
        logic [15:0] ofs;
    } decision_t;

endpackage

// File: rtl/el3_trap_eval.sv
module el3_trap_eval #(
    parameter bit EL3_PRESENT = 1'b1
) (
    input  logic ver_base,
    input  logic lower_trap_a,
    input  logic lower_pass_b,
    output logic trap_hit
);
    generate
        if (EL3_PRESENT) begin : g_el3
            logic hit_a;
            logic hit_b;
            always_comb begin
                hit_a    = ver_base & lower_trap_a;
                hit_b    = ~lower_pass_b;
                trap_hit = hit_a | hit_b;
            end
        end else begin : g_no_el3
            assign trap_hit = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/access_decode.sv
module access_decode
    import bwcap_gate_pkg::*;
#(
    parameter bit          EL3_PRESENT = 1'b1,
    parameter logic [5:0]  SYN_CLASS   = 6'h18,
    parameter logic [15:0] REDIR_OFS   = 16'h0910
) (
    input  logic       acc_valid,
    input  logic [1:0] acc_el,
    input  logic       feat_present,
    input  logic       hyp_cap,
    input  logic       ver_base,
    input  logic [2:0] nest_ctl,
    input  logic       lower_trap_a,
    input  logic       lower_pass_b,
    input  logic       sdd_undef,
    input  logic       sdd_prio,
    output decision_t  dec
);
    logic el3_hit;

    el3_trap_eval #(.EL3_PRESENT(EL3_PRESENT)) i_el3_trap_eval (
        .ver_base     (ver_base),
        .lower_trap_a (lower_trap_a),
        .lower_pass_b (lower_pass_b),
        .trap_hit     (el3_hit)
    );

    act_e act_d;
    logic nest_redir;
    logic nest_trap;

    always_comb begin
        nest_redir = nest_ctl[2] & nest_ctl[0];
        nest_trap  = nest_ctl[0];
        act_d      = ACT_NONE;
        if (acc_valid) begin
            if (!(feat_present && hyp_cap)) begin
                act_d = ACT_UNDEF;
            end else begin
                unique case (acc_el)
                    LVL_USER: act_d = ACT_UNDEF;
                    LVL_KERN: begin
                        if (nest_redir)     act_d = ACT_REDIR;
                        else if (nest_trap) act_d = el3_hit ? (sdd_undef ? ACT_UNDEF : ACT_TRAP3)
                                                            : ACT_TRAP2;
                        else                act_d = ACT_UNDEF;
                    end
                    LVL_HYP: begin
                        if (sdd_prio && el3_hit) act_d = ACT_UNDEF;
                        else if (el3_hit)        act_d = sdd_undef ? ACT_UNDEF : ACT_TRAP3;
                        else                     act_d = ACT_DIRECT;
                    end
                    default: act_d = ACT_DIRECT;
                endcase
            end
        end
        dec.act = act_d;
        dec.syn = (act_d == ACT_TRAP2 || act_d == ACT_TRAP3) ? SYN_CLASS : 6'd0;
        dec.ofs = (act_d == ACT_REDIR) ? REDIR_OFS : 16'd0;
    end
endmodule

// File: rtl/cap_reg_store.sv
module cap_reg_store #(
    parameter int DATA_W    = 64,
    parameter bit HAS_SCALE = 1'b1,
    parameter int FRAC_W    = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] value_q
);
    localparam int          FRAC_LSB  = 16 - FRAC_W;
    localparam logic [15:0] FRAC_MASK = 16'(((32'd1 << FRAC_W) - 32'd1) << FRAC_LSB);

    typedef struct packed {
        logic [DATA_W-1:0] value;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.value        = '0;
            st_d.value[63]    = HAS_SCALE ? wr_data[63] : 1'b0;
            st_d.value[62]    = wr_data[62];
            st_d.value[15:0]  = wr_data[15:0] & FRAC_MASK;
            if (HAS_SCALE && wr_data[63])
                st_d.value[31:16] = wr_data[31:16];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign value_q = st_q.value;

    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> $stable(value_q)); // R10
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        value_q[61:32] == '0); // R11
    AST_INT_NEEDS_SCALE: assert property (@(posedge clk) disable iff (!rst_n)
        !value_q[63] |-> value_q[31:16] == '0); // R11
endmodule

// File: rtl/hyp_bwcap_gate.sv
module hyp_bwcap_gate
    import bwcap_gate_pkg::*;
#(
    parameter bit          EL3_PRESENT = 1'b1,
    parameter bit          HAS_SCALE   = 1'b1,
    parameter int          FRAC_W      = 12,
    parameter logic [5:0]  SYN_CLASS   = 6'h18,
    parameter logic [15:0] REDIR_OFS   = 16'h0910
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        acc_valid,
    input  logic        acc_write,
    input  logic [1:0]  acc_el,
    input  logic [63:0] acc_wdata,
    input  logic        feat_present,
    input  logic        hyp_cap,
    input  logic        ver_base,
    input  logic [2:0]  nest_ctl,
    input  logic        lower_trap_a,
    input  logic        lower_pass_b,
    input  logic        sdd_undef,
    input  logic        sdd_prio,
    output logic        act_undef,
    output logic        act_trap_el2,
    output logic        act_trap_el3,
    output logic        act_redirect,
    output logic        act_direct,
    output logic [5:0]  syn_class,
    output logic [15:0] mem_ofs,
    output logic [63:0] rd_data
);
    localparam int DATA_W = 64;

    decision_t          dec;
    logic               wr_en;
    logic [DATA_W-1:0]  value_q;

    access_decode #(
        .EL3_PRESENT (EL3_PRESENT),
        .SYN_CLASS   (SYN_CLASS),
        .REDIR_OFS   (REDIR_OFS)
    ) i_access_decode (
        .acc_valid    (acc_valid),
        .acc_el       (acc_el),
        .feat_present (feat_present),
        .hyp_cap      (hyp_cap),
        .ver_base     (ver_base),
        .nest_ctl     (nest_ctl),
        .lower_trap_a (lower_trap_a),
        .lower_pass_b (lower_pass_b),
        .sdd_undef    (sdd_undef),
        .sdd_prio     (sdd_prio),
        .dec          (dec)
    );

    cap_reg_store #(
        .DATA_W    (DATA_W),
        .HAS_SCALE (HAS_SCALE),
        .FRAC_W    (FRAC_W)
    ) i_cap_reg_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (acc_wdata),
        .value_q (value_q)
    );

    always_comb begin
        act_undef    = (dec.act == ACT_UNDEF);
        act_trap_el2 = (dec.act == ACT_TRAP2);
        act_trap_el3 = (dec.act == ACT_TRAP3);
        act_redirect = (dec.act == ACT_REDIR);
        act_direct   = (dec.act == ACT_DIRECT);
        syn_class    = dec.syn;
        mem_ofs      = dec.ofs;
        wr_en        = act_direct & acc_write;
        rd_data      = (act_direct && !acc_write) ? value_q : '0;
    end

    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> $onehot({act_undef, act_trap_el2, act_trap_el3, act_redirect, act_direct})); // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> !(act_undef | act_trap_el2 | act_trap_el3 | act_redirect | act_direct)); // R1
    AST_NO_FEATURE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !(feat_present && hyp_cap)) |-> act_undef); // R2
    AST_USER_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_el == LVL_USER) |-> act_undef); // R3
    AST_TRAP_SYN: assert property (@(posedge clk) disable iff (!rst_n)
        (act_trap_el2 || act_trap_el3) |-> syn_class == SYN_CLASS); // R5
    AST_MON_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && feat_present && hyp_cap && acc_el == LVL_MON) |-> act_direct); // R9
    AST_SDD_NO_TRAP3: assert property (@(posedge clk) disable iff (!rst_n)
        sdd_undef |-> !act_trap_el3); // R8
endmodule

// File: tb/test_hyp_bwcap_gate.sv
module test_hyp_bwcap_gate;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        acc_valid, acc_write;
    logic [1:0]  acc_el;
    logic [63:0] acc_wdata;
    logic        feat_present, hyp_cap, ver_base;
    logic [2:0]  nest_ctl;
    logic        lower_trap_a, lower_pass_b, sdd_undef, sdd_prio;
    logic        act_undef, act_trap_el2, act_trap_el3, act_redirect, act_direct;
    logic [5:0]  syn_class;
    logic [15:0] mem_ofs;
    logic [63:0] rd_data;

    int n_run = 0;
    int n_fail = 0;

    localparam logic [4:0] A_UND = 5'b10000;
    localparam logic [4:0] A_T2  = 5'b01000;
    localparam logic [4:0] A_T3  = 5'b00100;
    localparam logic [4:0] A_RD  = 5'b00010;
    localparam logic [4:0] A_DIR = 5'b00001;
    localparam logic [4:0] A_NON = 5'b00000;

    always #10 clk = ~clk;

    hyp_bwcap_gate i_hyp_bwcap_gate (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_el(acc_el), .acc_wdata(acc_wdata), .feat_present(feat_present),
        .hyp_cap(hyp_cap), .ver_base(ver_base), .nest_ctl(nest_ctl),
        .lower_trap_a(lower_trap_a), .lower_pass_b(lower_pass_b),
        .sdd_undef(sdd_undef), .sdd_prio(sdd_prio), .act_undef(act_undef),
        .act_trap_el2(act_trap_el2), .act_trap_el3(act_trap_el3),
        .act_redirect(act_redirect), .act_direct(act_direct),
        .syn_class(syn_class), .mem_ofs(mem_ofs), .rd_data(rd_data)
    );

    task automatic idle();
        acc_valid = 0; acc_write = 0; acc_el = 2'd3; acc_wdata = '0;
        feat_present = 1; hyp_cap = 1; ver_base = 1; nest_ctl = 3'b000;
        lower_trap_a = 0; lower_pass_b = 1; sdd_undef = 0; sdd_prio = 0;
    endtask

    task automatic check_val(string req, logic [63:0] act, logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // present one read access for a cycle and check the action vector, syndrome and offset
    task automatic probe(string req, logic [1:0] el, logic [4:0] exp_act);
        @(negedge clk);
        acc_valid = 1; acc_write = 0; acc_el = el;
        #5;
        check_val(req, 64'({act_undef, act_trap_el2, act_trap_el3, act_redirect, act_direct}), 64'(exp_act));
        check_val({req, " syn"}, 64'(syn_class), (exp_act == A_T2 || exp_act == A_T3) ? 64'h18 : 64'h0);
        check_val({req, " ofs"}, 64'(mem_ofs), (exp_act == A_RD) ? 64'h0910 : 64'h0);
        @(negedge clk);
        acc_valid = 0;
    endtask

    task automatic write_at(logic [1:0] el, logic [63:0] d);
        @(negedge clk);
        acc_valid = 1; acc_write = 1; acc_el = el; acc_wdata = d;
        @(negedge clk);
        acc_valid = 0; acc_write = 0;
    endtask

    task automatic read_mon(string req, logic [63:0] exp);
        logic [1:0] s_el;
        logic [2:0] s_nest;
        s_el = acc_el; s_nest = nest_ctl;
        @(negedge clk);
        acc_valid = 1; acc_write = 0; acc_el = 2'd3;
        #5;
        check_val(req, rd_data, exp);
        @(negedge clk);
        acc_valid = 0; acc_el = s_el; nest_ctl = s_nest;
    endtask

    task automatic t_reset_idle();
        #5;
        check_val("R1 idle actions", 64'({act_undef, act_trap_el2, act_trap_el3, act_redirect, act_direct}), 64'(A_NON));
        check_val("R12 idle rdata", rd_data, 64'h0);
        read_mon("R12 reset value", 64'h0);
    endtask

    task automatic t_feature_gate();
        feat_present = 0;
        for (int el = 0; el < 4; el++) probe("R2 feature absent", 2'(el), A_UND);
        feat_present = 1; hyp_cap = 0;
        probe("R2 capability clear", 2'd3, A_UND);
        hyp_cap = 1;
    endtask

    task automatic t_user();
        nest_ctl = 3'b101;
        probe("R3 user level", 2'd0, A_UND);
        nest_ctl = 3'b000;
    endtask

    task automatic t_kernel();
        nest_ctl = 3'b101; lower_pass_b = 0; lower_trap_a = 1;
        probe("R4 redirect beats EL3 trap", 2'd1, A_RD);
        nest_ctl = 3'b111;
        probe("R4 redirect 111", 2'd1, A_RD);
        lower_pass_b = 1; lower_trap_a = 0; nest_ctl = 3'b001;
        probe("R5 trap to EL2", 2'd1, A_T2);
        nest_ctl = 3'b011;
        probe("R5 trap to EL2 bit1 set", 2'd1, A_T2);
        lower_trap_a = 1;
        probe("R5 trap_a with base version", 2'd1, A_T3);
        ver_base = 0;
        probe("R5 trap_a ignored without base version", 2'd1, A_T2);
        lower_trap_a = 0; lower_pass_b = 0;
        probe("R5 active-low pass", 2'd1, A_T3);
        sdd_undef = 1;
        probe("R8 sdd at EL1", 2'd1, A_UND);
        sdd_undef = 0; lower_pass_b = 1; ver_base = 1;
        nest_ctl = 3'b100;
        probe("R6 bit0 clear 100", 2'd1, A_UND);
        nest_ctl = 3'b110;
        probe("R6 bit0 clear 110", 2'd1, A_UND);
        nest_ctl = 3'b000;
    endtask

    task automatic t_hyp();
        probe("R9 hyp direct", 2'd2, A_DIR);
        sdd_prio = 1; sdd_undef = 1;
        probe("R9 hyp direct sdd ignored", 2'd2, A_DIR);
        sdd_undef = 0; lower_trap_a = 1;
        probe("R7 priority undef", 2'd2, A_UND);
        sdd_prio = 0;
        probe("R5 hyp trap to EL3", 2'd2, A_T3);
        sdd_undef = 1;
        probe("R8 sdd at EL2", 2'd2, A_UND);
        sdd_undef = 0; lower_trap_a = 0; lower_pass_b = 0; sdd_prio = 1;
        probe("R7 priority undef pass_b", 2'd2, A_UND);
        sdd_prio = 0; lower_pass_b = 1;
        lower_pass_b = 0;
        probe("R9 monitor always direct", 2'd3, A_DIR);
        lower_pass_b = 1;
    endtask

    task automatic t_storage();
        write_at(2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
        read_mon("R11 all ones with scale", 64'hC000_0000_FFFF_FFF0);
        write_at(2'd3, 64'h7FFF_FFFF_1234_5678);
        read_mon("R11 no scale int cleared", 64'h4000_0000_0000_5670);
        lower_trap_a = 1;
        write_at(2'd2, 64'h8000_0000_0001_0000);
        read_mon("R10 trapped write ignored", 64'h4000_0000_0000_5670);
        lower_trap_a = 0;
        write_at(2'd0, 64'hFFFF_FFFF_FFFF_FFFF);
        read_mon("R10 user write ignored", 64'h4000_0000_0000_5670);
        nest_ctl = 3'b101;
        write_at(2'd1, 64'h0);
        read_mon("R10 redirected write ignored", 64'h4000_0000_0000_5670);
        nest_ctl = 3'b000;
        write_at(2'd2, 64'h8000_0000_ABCD_1238);
        read_mon("R10 hyp direct write", 64'h8000_0000_ABCD_1230);
        @(negedge clk);
        acc_valid = 1; acc_write = 0; acc_el = 2'd1; nest_ctl = 3'b001;
        #5;
        check_val("R12 rdata zero on trap", rd_data, 64'h0);
        @(negedge clk);
        acc_valid = 0; nest_ctl = 3'b000;
    endtask

    initial begin
        #(200000 * 20);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        idle();
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        t_reset_idle();
        t_feature_gate();
        t_user();
        t_kernel();
        t_hyp();
        t_storage();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule